// File: doc/BRIEF.md
# Dual-Port RAM with Cross-Port Mailbox Interrupts

This block is a synchronous memory of 8192 bytes with two fully independent access ports, called left and right, running on one shared clock. Each port has an active-low select, an active-low write strobe, an active-low read enable, a 13-bit address, separate write and read data buses, an active-low busy input and an active-low interrupt output. Read data is registered and appears one clock after the access is presented.

The two highest locations serve as mailboxes between the ports. The top location (0x1FFF) carries messages from left to right. A left write there raises the right interrupt, and a right read of it lowers that interrupt again. The location below it (0x1FFE) carries messages from right to left in the same way. Both locations still hold data like any other word, so the message byte travels with the interrupt. A low busy input on a port prevents its mailbox access from changing a flag. If a set and a clear of the same flag meet in one cycle, the set takes effect, so no message is lost.

Top module: `mbox_dpram`

## Requirements
- R1: A write (select low, write strobe low) stores the byte. A read (select low, write strobe high, read enable low) puts the stored byte on that port's read bus one clock later. In all other cycles the read bus holds its value.
- R2: A left write to 0x1FFF while left busy is high drives the right interrupt low after that clock edge.
- R3: A right access to 0x1FFF with select low and read enable low, while right busy is high, returns the right interrupt high after that clock edge.
- R4: A right write to 0x1FFE while right busy is high drives the left interrupt low after that clock edge.
- R5: A left access to 0x1FFE with select low and read enable low, while left busy is high, returns the left interrupt high after that clock edge.
- R6: A mailbox write while the writer's busy is low leaves the flag unchanged. A mailbox clear while the reader's busy is low also leaves the flag unchanged. With no set and no clear request, both interrupts hold their value.
- R7: If a flag gets a set request and a clear request in the same cycle, the flag ends up set (interrupt low).
- R8: A synchronous reset (active low) drives both interrupts high and both read buses to zero.
- R9: The mailbox locations store and return data like ordinary locations.
- R10: A write by a port to the mailbox that serves it, a write to any non-mailbox address, and a read by a port of the mailbox it writes all leave both interrupts unchanged.
- R11: When both ports write the same address in the same cycle, the left port's byte is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| l_cs_n | input | 1 | Left select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left read enable, active low |
| l_addr | input | 13 | Left word address |
| l_wdata | input | 8 | Left write data |
| l_busy_n | input | 1 | Left busy, low blocks left mailbox flag updates |
| l_rdata | output | 8 | Left registered read data |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_cs_n | input | 1 | Right select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right read enable, active low |
| r_addr | input | 13 | Right word address |
| r_wdata | input | 8 | Right write data |
| r_busy_n | input | 1 | Right busy, low blocks right mailbox flag updates |
| r_rdata | output | 8 | Right registered read data |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
Every result of this block is due exactly one clock after the access that causes it. This holds for read data, for an interrupt going low on a mailbox write and for an interrupt going high on a mailbox read. The bench drives each access on a falling edge and lets one rising edge pass. It then samples both interrupts and both read buses on the next falling edge, so each check sees the state the access produced and nothing later. For the requirements that say nothing changes, the same sample point confirms the interrupts kept their earlier level. Busy-blocked attempts, own-mailbox writes and set/clear races are each run from a known flag state.

// File: rtl/mbox_dpram_pkg.sv
package mbox_dpram_pkg;

  // Index of a mailbox location for a given address width:
  // upper = 1 selects the top word (left-to-right messages),
  // upper = 0 selects the word below it (right-to-left messages).
  function automatic int unsigned mbox_index(int unsigned aw, bit upper);
    int unsigned top;
    top = (32'd1 << aw) - 32'd1;
    return upper ? top : top - 32'd1;
  endfunction

  // Next state of an interrupt flag (1 = pending); a set beats a clear.
  function automatic logic flag_next(logic cur, logic set, logic clr);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

endpackage

// File: rtl/mbox_dpram_array.sv
module mbox_dpram_array #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_wr,
  input  logic              l_rd,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_wr,
  input  logic              r_rd,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Right write first, left write last: on a same-address collision
  // the left byte is the one kept.
  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
  end

  // Registered read ports, value held between reads.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_rd) l_rdata <= mem[l_addr];
      if (r_rd) r_rdata <= mem[r_addr];
    end
  end
endmodule

// File: rtl/mbox_dpram_port_dec.sv
module mbox_dpram_port_dec #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] SEND_ADDR = '1,
  parameter logic [ADDR_W-1:0] RECV_ADDR = '1
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_en,
  output logic              rd_en,
  output logic              peer_set,
  output logic              own_clr
);
  logic sel, hit_send, hit_recv;

  assign sel      = !cs_n;
  assign hit_send = (addr == SEND_ADDR);
  assign hit_recv = (addr == RECV_ADDR);

  assign wr_en    = sel && !we_n;
  assign rd_en    = sel && we_n && !oe_n;
  // Writing the send mailbox signals the peer.
  assign peer_set = wr_en && hit_send && busy_n;
  // Reading the receive mailbox acknowledges this port's interrupt.
  assign own_clr  = sel && !oe_n && hit_recv && busy_n;
endmodule

// File: rtl/mbox_dpram_flag.sv
module mbox_dpram_flag
  import mbox_dpram_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic pend;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= flag_next(pend, set, clr);
  end

  assign irq_n = !pend;
endmodule

// File: rtl/mbox_dpram.sv
module mbox_dpram
  import mbox_dpram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_n,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_n,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] BOX_TO_R = ADDR_W'(mbox_index(ADDR_W, 1'b1));
  localparam logic [ADDR_W-1:0] BOX_TO_L = ADDR_W'(mbox_index(ADDR_W, 1'b0));

  // Named internal events, visible to the bound checker.
  logic l_wr, l_rd, r_wr, r_rd;
  logic ev_set_r, ev_clr_r, ev_set_l, ev_clr_l;

  mbox_dpram_port_dec #(
    .ADDR_W(ADDR_W), .SEND_ADDR(BOX_TO_R), .RECV_ADDR(BOX_TO_L)
  ) dec_l_i (
    .cs_n(l_cs_n), .we_n(l_we_n), .oe_n(l_oe_n), .busy_n(l_busy_n),
    .addr(l_addr), .wr_en(l_wr), .rd_en(l_rd),
    .peer_set(ev_set_r), .own_clr(ev_clr_l)
  );

  mbox_dpram_port_dec #(
    .ADDR_W(ADDR_W), .SEND_ADDR(BOX_TO_L), .RECV_ADDR(BOX_TO_R)
  ) dec_r_i (
    .cs_n(r_cs_n), .we_n(r_we_n), .oe_n(r_oe_n), .busy_n(r_busy_n),
    .addr(r_addr), .wr_en(r_wr), .rd_en(r_rd),
    .peer_set(ev_set_l), .own_clr(ev_clr_r)
  );

  mbox_dpram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk(clk), .rst_n(rst_n),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_wr(r_wr), .r_rd(r_rd), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  mbox_dpram_flag flag_l_i (
    .clk(clk), .rst_n(rst_n), .set(ev_set_l), .clr(ev_clr_l), .irq_n(l_irq_n)
  );

  mbox_dpram_flag flag_r_i (
    .clk(clk), .rst_n(rst_n), .set(ev_set_r), .clr(ev_clr_r), .irq_n(r_irq_n)
  );
endmodule

// File: rtl/mbox_dpram_chk.sv
module mbox_dpram_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              l_cs_n,
  input logic              l_we_n,
  input logic              l_oe_n,
  input logic [ADDR_W-1:0] l_addr,
  input logic              l_busy_n,
  input logic              l_irq_n,
  input logic              r_cs_n,
  input logic              r_we_n,
  input logic              r_oe_n,
  input logic [ADDR_W-1:0] r_addr,
  input logic              r_busy_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TOP  = '1;
  localparam logic [ADDR_W-1:0] NEXT = TOP - ADDR_W'(1);

  logic want_set_r, want_clr_r, want_set_l, want_clr_l;
  assign want_set_r = !l_cs_n && !l_we_n && (l_addr == TOP)  && l_busy_n;
  assign want_clr_r = !r_cs_n && !r_oe_n && (r_addr == TOP)  && r_busy_n;
  assign want_set_l = !r_cs_n && !r_we_n && (r_addr == NEXT) && r_busy_n;
  assign want_clr_l = !l_cs_n && !l_oe_n && (l_addr == NEXT) && l_busy_n;

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (l_irq_n && r_irq_n)); // R8
  AST_SET_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    want_set_r |=> !r_irq_n); // R2
  AST_CLR_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (want_clr_r && !want_set_r) |=> r_irq_n); // R3
  AST_SET_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    want_set_l |=> !l_irq_n); // R4
  AST_CLR_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (want_clr_l && !want_set_l) |=> l_irq_n); // R5
  AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (!want_set_r && !want_clr_r) |=> $stable(r_irq_n)); // R6
  AST_HOLD_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (!want_set_l && !want_clr_l) |=> $stable(l_irq_n)); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (want_set_r && want_clr_r) |=> !r_irq_n); // R7
endmodule

bind mbox_dpram mbox_dpram_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
  .l_busy_n(l_busy_n), .l_irq_n(l_irq_n),
  .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
  .r_busy_n(r_busy_n), .r_irq_n(r_irq_n)
);

// File: tb/mbox_dpram_tb_top.sv
`timescale 1ns/1ps
module mbox_dpram_tb_top;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam logic [AW-1:0] TO_R = 13'h1FFF;
  localparam logic [AW-1:0] TO_L = 13'h1FFE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n = 1, l_we_n = 1, l_oe_n = 1, l_busy_n = 1;
  logic r_cs_n = 1, r_we_n = 1, r_oe_n = 1, r_busy_n = 1;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mbox_dpram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_busy_n(l_busy_n), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_busy_n(r_busy_n), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One access cycle: inputs already set on a falling edge; let one rising
  // edge capture them, return on the next falling edge for sampling.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1;
    r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1;
  endtask

  task automatic l_write(logic [AW-1:0] a, logic [DW-1:0] d, logic busy);
    l_cs_n = 0; l_we_n = 0; l_oe_n = 1; l_addr = a; l_wdata = d; l_busy_n = busy;
  endtask
  task automatic r_write(logic [AW-1:0] a, logic [DW-1:0] d, logic busy);
    r_cs_n = 0; r_we_n = 0; r_oe_n = 1; r_addr = a; r_wdata = d; r_busy_n = busy;
  endtask
  task automatic l_read(logic [AW-1:0] a, logic busy);
    l_cs_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = a; l_busy_n = busy;
  endtask
  task automatic r_read(logic [AW-1:0] a, logic busy);
    r_cs_n = 0; r_we_n = 1; r_oe_n = 0; r_addr = a; r_busy_n = busy;
  endtask

  task automatic t_reset_state();
    check("R8", "l_irq_n after reset", l_irq_n, 1);
    check("R8", "r_irq_n after reset", r_irq_n, 1);
    check("R8", "l_rdata after reset", l_rdata, 0);
    check("R8", "r_rdata after reset", r_rdata, 0);
  endtask

  task automatic t_plain_rw();
    idle(); l_write(13'h0010, 8'hA5, 1); r_write(13'h0020, 8'h3C, 1); tick();
    idle(); l_read(13'h0020, 1); r_read(13'h0010, 1); tick();
    check("R1", "left reads right's byte", l_rdata, 8'h3C);
    check("R1", "right reads left's byte", r_rdata, 8'hA5);
    idle(); l_addr = 13'h0010; r_addr = 13'h0020; tick();
    check("R1", "left bus holds when idle", l_rdata, 8'h3C);
    check("R1", "right bus holds when idle", r_rdata, 8'hA5);
    idle(); r_read(13'h0010, 1); r_oe_n = 1; tick();
    check("R1", "right bus holds, oe high", r_rdata, 8'hA5);
    idle();
  endtask

  task automatic t_mbox_to_right();
    idle(); l_write(TO_R, 8'h77, 1); tick();
    check("R2", "r_irq_n after left mailbox write", r_irq_n, 0);
    check("R2", "l_irq_n untouched", l_irq_n, 1);
    idle(); r_read(TO_R, 1); tick();
    check("R3", "r_irq_n after right mailbox read", r_irq_n, 1);
    check("R9", "right reads mailbox byte", r_rdata, 8'h77);
    idle();
  endtask

  task automatic t_mbox_to_left();
    idle(); r_write(TO_L, 8'h99, 1); tick();
    check("R4", "l_irq_n after right mailbox write", l_irq_n, 0);
    check("R4", "r_irq_n untouched", r_irq_n, 1);
    idle(); l_read(TO_L, 1); tick();
    check("R5", "l_irq_n after left mailbox read", l_irq_n, 1);
    check("R9", "left reads mailbox byte", l_rdata, 8'h99);
    idle();
  endtask

  task automatic t_busy();
    idle(); l_write(TO_R, 8'h01, 0); tick();
    check("R6", "left busy blocks set", r_irq_n, 1);
    idle(); r_write(TO_L, 8'h02, 0); tick();
    check("R6", "right busy blocks set", l_irq_n, 1);
    idle(); l_write(TO_R, 8'h03, 1); r_write(TO_L, 8'h04, 1); tick();
    check("R6", "r flag set for busy-clear test", r_irq_n, 0);
    check("R6", "l flag set for busy-clear test", l_irq_n, 0);
    idle(); r_read(TO_R, 0); l_read(TO_L, 0); tick();
    check("R6", "right busy blocks clear", r_irq_n, 0);
    check("R6", "left busy blocks clear", l_irq_n, 0);
    idle(); tick();
    check("R6", "r flag holds with no request", r_irq_n, 0);
    idle(); r_read(TO_R, 1); l_read(TO_L, 1); tick();
    check("R6", "r flag cleared once busy high", r_irq_n, 1);
    check("R6", "l flag cleared once busy high", l_irq_n, 1);
    idle();
  endtask

  task automatic t_race();
    idle(); l_write(TO_R, 8'h55, 1); r_read(TO_R, 1); tick();
    check("R7", "right set beats clear (from idle)", r_irq_n, 0);
    idle(); l_write(TO_R, 8'h56, 1); r_read(TO_R, 1); tick();
    check("R7", "right set beats clear (pending)", r_irq_n, 0);
    idle(); r_write(TO_L, 8'h66, 1); l_read(TO_L, 1); tick();
    check("R7", "left set beats clear", l_irq_n, 0);
    idle(); r_read(TO_R, 1); l_read(TO_L, 1); tick();
    check("R7", "cleanup clears right", r_irq_n, 1);
    check("R7", "cleanup clears left", l_irq_n, 1);
    idle();
  endtask

  task automatic t_no_effect();
    idle(); r_write(TO_R, 8'h21, 1); l_write(TO_L, 8'h12, 1); tick();
    check("R10", "own-mailbox write leaves r_irq_n", r_irq_n, 1);
    check("R10", "own-mailbox write leaves l_irq_n", l_irq_n, 1);
    idle(); l_write(13'h1FFD, 8'h33, 1); r_write(13'h0000, 8'h44, 1); tick();
    check("R10", "plain write leaves r_irq_n", r_irq_n, 1);
    check("R10", "plain write leaves l_irq_n", l_irq_n, 1);
    idle(); l_write(TO_R, 8'h88, 1); tick();
    idle(); l_read(TO_R, 1); tick();
    check("R10", "left reading its send box keeps r flag", r_irq_n, 0);
    check("R9", "left reads back its send box", l_rdata, 8'h88);
    idle(); r_read(TO_R, 1); tick();
    check("R10", "right clear still works", r_irq_n, 1);
    idle();
  endtask

  task automatic t_collide();
    idle(); l_write(13'h0100, 8'h11, 1); r_write(13'h0100, 8'h22, 1); tick();
    idle(); r_read(13'h0100, 1); tick();
    check("R11", "collision keeps left byte", r_rdata, 8'h11);
    idle();
  endtask

  task automatic t_reset_again();
    idle(); l_write(TO_R, 8'h5A, 1); r_write(TO_L, 8'hA5, 1); tick();
    idle(); rst_n = 0; tick();
    check("R8", "reset clears pending r flag", r_irq_n, 1);
    check("R8", "reset clears pending l flag", l_irq_n, 1);
    rst_n = 1; tick();
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_plain_rw();
    t_mbox_to_right();
    t_mbox_to_left();
    t_busy();
    t_race();
    t_no_effect();
    t_collide();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual still running, expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule